// File: doc/BRIEF.md
# Cascadable Parallel-In Serial-Out Register

This block captures a parallel word and sends it out one bit at a time, most significant bit first. While the active-low load input is low, every stage copies the parallel bus. The copy is level-sensitive and transparent, so the serial output follows the top bit of the bus for as long as load stays low. Once load is high, each rising edge of the OR of the shift clock and the active-low enable moves the word one place toward the last stage. The serial input fills stage 0 on each shift. The last stage drives a true and a complemented serial output. Tying the true output of one instance to the serial input of the next makes a longer converter.

Everything runs on one free-running system clock `clk`. The load, the combined shift clock (`sclk | sclk_en_n`) and the serial input are sampled through a synchroniser chain of `SYNC_STAGES` flops. The parallel bus is sampled directly, so it must be stable relative to `clk`. A small state machine watches the synchronised combined clock and load. It has three states. `ST_LOAD` means load is active. `ST_ARMED` means load is released and the combined clock is low. `ST_HELD` means load is released and the combined clock is high. Its transitions are:
- any state to `ST_LOAD` while load is low;
- `ST_LOAD` to `ST_HELD` or `ST_ARMED` on release, according to the combined clock;
- `ST_ARMED` to `ST_HELD` when the combined clock goes high, which is the shift event;
- `ST_HELD` to `ST_ARMED` when the combined clock goes low.

From that state and its inputs the machine issues one command per cycle to the stage bank: hold, load or shift.

Top module: `piso_shift_reg`

## Requirements
- R1: While the synchronised load is low, all stages take `par_din` on every cycle, whatever the shift clock, enable and serial input do.
- R2: While load is held low, a change on `par_din[DATA_W-1]` appears on `ser_out` one system clock edge later, with no shift clock edge.
- R3: With load high, a rising edge of `sclk | sclk_en_n` moves stage i to stage i+1 and puts `ser_din` into stage 0. `ser_out` is the top stage, so a loaded word leaves with `par_din[DATA_W-1]` first, and zeros follow when `ser_din` is 0.
- R4: While `sclk_en_n` is high, toggling `sclk` causes no shift. The enable may be lowered while `sclk` is high and then `sclk` lowered, still without a shift.
- R5: The two clock inputs are interchangeable. A pulse on `sclk_en_n` with `sclk` low shifts exactly like a pulse on `sclk` with the enable low.
- R6: `ser_out_n` is the complement of `ser_out` on every cycle.
- R7: If the combined clock is high in the cycle in which load is released, that is not a shift event. The same applies if it rises in that cycle.
- R8: With the default of two synchroniser flops, a change on load, `sclk`, `sclk_en_n` or `ser_din` takes effect at `ser_out` on the third rising `clk` edge after it is applied, and not earlier.
- R9: Synchronous active-high `rst` clears all stages (`ser_out` = 0, `ser_out_n` = 1). It presets the sampled combined clock to high, so a combined clock that is high when reset ends is not a shift event.
- R10: Two instances chained, with the first one's `ser_out` driving the second one's `ser_din` and sharing clocks and load, shift out 16 bits in order: the second word MSB first, then the first word MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst | input | 1 | synchronous reset, active high |
| load_n | input | 1 | parallel load, active low, level-sensitive |
| par_din | input | DATA_W | parallel word; bit DATA_W-1 leaves first |
| ser_din | input | 1 | serial input into stage 0 |
| sclk | input | 1 | shift clock, rising edge active |
| sclk_en_n | input | 1 | shift enable, active low, OR-ed with `sclk` |
| ser_out | output | 1 | last stage |
| ser_out_n | output | 1 | complement of last stage |

## Verification
The bound checker tests on every cycle the following:
- a load command leaves the stages equal to the bus;
- a hold command leaves them unchanged;
- a shift moves them one place with the sampled serial bit at stage 0;
- no two shifts come on consecutive cycles;
- release of load with the combined clock high gives no shift;
- the two outputs stay complementary;
- reset leaves all stages at zero.

Only the bench scenarios can show the behaviour at the ports. These are the bit order of a full word, the exact three-edge latency, transparency under a held load, the swapped roles of clock and enable, and the 16-bit order through a two-instance chain. The bench compares against a behavioural model of both instances on every clock.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // edge tracker states of the combined shift clock
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,   // load active, stages follow the bus
        ST_ARMED = 2'd1,   // load released, combined clock low
        ST_HELD  = 2'd2    // load released, combined clock high
    } edge_state_t;

    // command to the stage bank for the current cycle
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_SHIFT = 2'd2
    } stage_cmd_t;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_flop
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_n_s,   // synchronised load, active low
    input  logic       comb_s,     // synchronised OR of clock and enable
    output stage_cmd_t cmd,
    output edge_state_t state
);

    edge_state_t state_q;
    edge_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HELD;   // history preset high: no edge at start
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!load_n_s) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD:  state_d = comb_s ? ST_HELD : ST_ARMED;
                ST_ARMED: state_d = comb_s ? ST_HELD : ST_ARMED;
                ST_HELD:  state_d = comb_s ? ST_HELD : ST_ARMED;
                default:  state_d = ST_HELD;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd = CMD_HOLD;
        if (!load_n_s) begin
            cmd = CMD_LOAD;
        end else begin
            unique case (state_q)
                ST_ARMED: cmd = comb_s ? CMD_SHIFT : CMD_HOLD;
                ST_LOAD,
                ST_HELD:  cmd = CMD_HOLD;
                default:  cmd = CMD_HOLD;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_cmd_t        cmd,
    input  logic [DATA_W-1:0] par_din,
    input  logic              ser_bit,
    output logic [DATA_W-1:0] stages
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_head
            assign shift_src = ser_bit;
        end else begin : g_body
            assign shift_src = stages[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stages[i] <= 1'b0;
            end else begin
                unique case (cmd)
                    CMD_LOAD:  stages[i] <= par_din[i];
                    CMD_SHIFT: stages[i] <= shift_src;
                    CMD_HOLD:  stages[i] <= stages[i];
                    default:   stages[i] <= stages[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic [DATA_W-1:0] par_din,
    input  logic              ser_din,
    input  logic              sclk,
    input  logic              sclk_en_n,
    output logic              ser_out,
    output logic              ser_out_n
);

    localparam int          SYNC_W   = 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b110; // load idle, comb high, ser 0

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              load_s;
    logic              comb_s;
    logic              ser_s;
    stage_cmd_t        cmd;
    edge_state_t       state;
    logic [DATA_W-1:0] stages;

    // the OR of clock and enable is the single shift clock
    assign raw_in = {load_n, sclk | sclk_en_n, ser_din};

    piso_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (synced)
    );

    assign load_s = synced[2];
    assign comb_s = synced[1];
    assign ser_s  = synced[0];

    piso_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_n_s (load_s),
        .comb_s   (comb_s),
        .cmd      (cmd),
        .state    (state)
    );

    piso_stages #(
        .DATA_W (DATA_W)
    ) u_stages (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .par_din (par_din),
        .ser_bit (ser_s),
        .stages  (stages)
    );

    assign ser_out   = stages[DATA_W-1];
    assign ser_out_n = ~stages[DATA_W-1];

endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk
    import piso_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input stage_cmd_t        cmd,
    input logic [DATA_W-1:0] stages,
    input logic [DATA_W-1:0] par_din,
    input logic              load_s,
    input logic              comb_s,
    input logic              ser_s,
    input logic              ser_out,
    input logic              ser_out_n
);

    assert_load_copies_bus_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (stages == $past(par_din)));

    assert_shift_moves_one_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SHIFT) |=> (stages == {$past(stages[DATA_W-2:0]), $past(ser_s)}));

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(stages));

    assert_one_shift_per_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SHIFT) |=> (cmd != CMD_SHIFT));

    assert_outputs_complement_R6: assert property (@(posedge clk) disable iff (rst)
        ser_out_n == !ser_out);

    assert_no_shift_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(load_s) && comb_s) |-> (cmd == CMD_HOLD));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stages == '0 && !ser_out));

endmodule

bind piso_shift_reg piso_shift_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .stages    (stages),
    .par_din   (par_din),
    .load_s    (load_s),
    .comb_s    (comb_s),
    .ser_s     (ser_s),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
);

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic [W-1:0] par_a = '0;
    logic [W-1:0] par_b = '0;
    logic         ser_a = 1'b0;
    logic         sclk = 1'b0;
    logic         sclk_en_n = 1'b0;
    logic         out_a, out_an, out_b, out_bn;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    piso_shift_reg #(.DATA_W(W)) i_piso_shift_reg (
        .clk(clk), .rst(rst), .load_n(load_n), .par_din(par_a),
        .ser_din(ser_a), .sclk(sclk), .sclk_en_n(sclk_en_n),
        .ser_out(out_a), .ser_out_n(out_an));

    piso_shift_reg #(.DATA_W(W)) i_piso_shift_reg_b (
        .clk(clk), .rst(rst), .load_n(load_n), .par_din(par_b),
        .ser_din(out_a), .sclk(sclk), .sclk_en_n(sclk_en_n),
        .ser_out(out_b), .ser_out_n(out_bn));

    // behavioural reference: inputs act two edges after sampling
    typedef struct { bit ld; bit cb; bit sa; bit sb; } smp_t;
    smp_t hist[$];
    smp_t d, nw;
    bit   ma[$];
    bit   mb[$];
    bit   mprev;

    always @(posedge clk) begin
        if (rst) begin
            nw.ld = 1; nw.cb = 1; nw.sa = 0; nw.sb = 0;
            hist = {};
            hist.push_back(nw);
            hist.push_back(nw);
            ma = {}; mb = {};
            for (int i = 0; i < W; i++) begin ma.push_back(0); mb.push_back(0); end
            mprev = 1;
        end else begin
            d = hist.pop_front();
            nw.ld = load_n; nw.cb = sclk | sclk_en_n; nw.sa = ser_a; nw.sb = ma[W-1];
            hist.push_back(nw);
            if (!d.ld) begin
                ma = {}; mb = {};
                for (int i = 0; i < W; i++) begin ma.push_back(par_a[i]); mb.push_back(par_b[i]); end
                mprev = 1;
            end else begin
                if (d.cb && !mprev) begin
                    ma.push_front(d.sa); void'(ma.pop_back());
                    mb.push_front(d.sb); void'(mb.pop_back());
                end
                mprev = d.cb;
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, out_a, ma[W-1]);
            check(cur_req, out_b, mb[W-1]);
            check("R6", out_an, !out_a);
            check("R6", out_bn, !out_b);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; tick(3);
        sclk = 1'b0; tick(3);
    endtask

    task automatic load_word(logic [W-1:0] a, logic [W-1:0] b);
        par_a = a; par_b = b; load_n = 1'b0; tick(4);
        load_n = 1'b1; tick(4);
    endtask

    initial begin
        logic [W-1:0] word;
        logic [2*W-1:0] chain;

        // R9: reset with combined clock high
        sclk = 1'b1; ser_a = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(1);
        check("R9", out_a, 1'b0);
        check("R9", out_an, 1'b1);
        tick(4);
        sclk = 1'b0; ser_a = 1'b0; tick(4);

        // R1 and R3: load ignores clock activity, then word leaves MSB first
        cur_req = "R1";
        word = 8'hB4;
        par_a = word; load_n = 1'b0;
        for (int k = 0; k < 3; k++) begin sclk = ~sclk; tick(2); end
        sclk = 1'b0; tick(4);
        check("R1", out_a, word[W-1]);
        load_n = 1'b1; tick(4);
        cur_req = "R3";
        // R8: first shift shows on the third edge only
        sclk = 1'b1; tick(2);
        check("R8", out_a, word[W-1]);
        tick(1);
        check("R8", out_a, word[W-2]);
        sclk = 1'b0; tick(3);
        for (int k = 2; k <= W; k++) begin
            pulse_sclk();
            check("R3", out_a, (k < W) ? word[W-1-k] : 1'b0);
        end
        pulse_sclk();
        check("R3", out_a, 1'b0);

        // R4: enable high blocks the shift clock
        cur_req = "R4";
        sclk_en_n = 1'b1;
        load_word(8'h9A, 8'h00);
        for (int k = 0; k < 4; k++) begin
            pulse_sclk();
            check("R4", out_a, 1'b1);
        end
        sclk = 1'b1; tick(3);
        sclk_en_n = 1'b0; tick(3);
        sclk = 1'b0; tick(4);
        check("R4", out_a, 1'b1);

        // R5: enable used as the clock
        cur_req = "R5";
        load_word(8'h40, 8'h00);
        check("R5", out_a, 1'b0);
        sclk_en_n = 1'b1; tick(3);
        check("R5", out_a, 1'b1);
        sclk_en_n = 1'b0; tick(3);
        check("R5", out_a, 1'b1);

        // R7: release load with combined clock high
        cur_req = "R7";
        sclk = 1'b1;
        par_a = 8'h80; load_n = 1'b0; tick(4);
        load_n = 1'b1; tick(6);
        check("R7", out_a, 1'b1);
        sclk = 1'b0; tick(4);
        check("R7", out_a, 1'b1);

        // R2: transparency while load held low
        cur_req = "R2";
        load_n = 1'b0; tick(4);
        for (int k = 0; k < 6; k++) begin
            par_a = (k % 2 == 0) ? 8'h80 : 8'h7F;
            tick(1);
            check("R2", out_a, par_a[W-1]);
        end
        load_n = 1'b1; tick(4);

        // R10: two-stage chain, 16 bits
        cur_req = "R10";
        load_word(8'hC3, 8'h29);
        chain = {8'h29, 8'hC3};
        check("R10", out_b, chain[2*W-1]);
        for (int k = 1; k < 2*W; k++) begin
            pulse_sclk();
            check("R10", out_b, chain[2*W-1-k]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule